// File: doc/BRIEF.md
# Serial Host Bus to Parallel Flash Read Bridge

This block lets a host that fetches boot firmware over the four-bit Low Pin Count (LPC) bus read it from an ordinary parallel NOR flash. It runs entirely on the host's bus clock, with no oscillator of its own. It watches the frame strobe and the four-bit nibble bus, and decodes memory read cycles. For each one it drives a flash address and pulls the flash output enable low for a fixed minimum number of clocks. It then latches the byte and returns it to the host with the usual turnaround, wait and ready phases. To the host, the bridge looks like a normal bus flash part.

The host scans a large address window, but only the low image-sized part of each address reaches the flash. A small boot image therefore appears repeatedly across the whole window. A bank-select input places that image at one of several equal slots in the flash, so one part can hold several images. With the default parameters the image is 256 KB and the host sends a 32-bit address. Four banks fill a 1 MB region of a 21-bit flash address space.

Top module: `lpc_nor_bridge`

## Requirements
- R1: After reset the nibble bus is not driven (`nib_oe` = 0), and both `nor_oe_n` and `nor_we_n` are high.
- R2: A cycle starts on a clock where `frame_n` is low and `nib_i` = 4'b0000. The next nibble is the cycle type. Only 4'b0100 (memory read) is served. Any other type leaves the nibble bus undriven and `nor_oe_n` high until the next start.
- R3: Eight address nibbles follow the type nibble, most significant first. `nor_addr[17:0]` equals host address bits [17:0]. Host bits [31:18] have no effect, so the image is mirrored across the window. `nor_addr` stays stable while `nor_oe_n` is low.
- R4: The flash address is `img_bank` × 2^18 plus the low 18 host bits. `img_bank` is sampled together with the last address nibble.
- R5: `nor_we_n` stays high at all times.
- R6: `nor_oe_n` goes low only during a served read. It stays low for at least 3 clocks before the data byte is latched, so a flash that becomes valid only in the third low clock returns correct data.
- R7: The response works as follows:
  - For the two clocks after the last address nibble, the bridge leaves the bus undriven.
  - It then drives 4'b0101 (wait) for at least one clock.
  - Next come 4'b0000 (ready), then the low data nibble, then the high data nibble.
  - It then drives 4'b1111 for one clock and releases the bus.
- R8: `frame_n` low in the middle of a cycle with a nonzero nibble aborts the cycle. On the next clock the bus is released and `nor_oe_n` is high. No data is returned.
- R9: A new start may follow directly after a completed or aborted cycle, with no idle clocks, and it is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock; the only clock of the block |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low cycle framing strobe from the host |
| nib_i | input | 4 | Nibble bus value seen from the host |
| nib_o | output | 4 | Nibble value the bridge drives |
| nib_oe | output | 1 | High while the bridge drives the nibble bus |
| img_bank | input | 2 | Selects which image slot of the flash is exposed |
| nor_addr | output | 21 | Parallel flash address |
| nor_data | input | 8 | Parallel flash data |
| nor_oe_n | output | 1 | Active-low flash output enable |
| nor_we_n | output | 1 | Active-low flash write enable (held inactive) |

## Verification
The bench drives addresses whose upper host bits differ but whose low 18 bits match. A design that passed the upper bits through, or dropped the bank offset, would put the wrong address out and return the wrong byte. Its flash model returns garbage until the output enable has been low for three clocks, so a bridge that latches early gives wrong data. The bench also sends write and I/O cycle types, aborts a cycle both in the address phase and in the wait phase, and starts cycles back to back. A faulty bridge would then answer a cycle it should ignore, keep the bus or the flash enabled after an abort, or miss the following start.

// File: rtl/lpc_nor_pkg.sv
package lpc_nor_pkg;

   // bus cycle sequencer states
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTYP,
      ST_ADDR,
      ST_HTAR0,
      ST_HTAR1,
      ST_SWAIT,
      ST_SRDY,
      ST_DLO,
      ST_DHI,
      ST_TTAR0,
      ST_TTAR1
   } bus_st_e;

   localparam logic [3:0] NIB_START = 4'b0000;
   localparam logic [3:0] NIB_MEMRD = 4'b0100;
   localparam logic [3:0] SYNC_LONG = 4'b0101;
   localparam logic [3:0] SYNC_DONE = 4'b0000;
   localparam logic [3:0] NIB_IDLE  = 4'b1111;

endpackage

// File: rtl/lpc_nor_addr.sv
module lpc_nor_addr #(
   parameter int IMG_AW = 18,
   parameter int BANK_W = 2,
   parameter int FA_W   = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nib_en,
   input  logic              nib_last,
   input  logic [3:0]        nib,
   input  logic [BANK_W-1:0] bank,
   output logic [FA_W-1:0]   fl_addr
);

   localparam int SH_W  = IMG_AW - 4;
   localparam int SUM_W = IMG_AW + BANK_W;
   localparam int WIDE  = (FA_W > SUM_W) ? FA_W : SUM_W;

   generate
      if (IMG_AW <= 4) begin : g_bad_img
         $error("lpc_nor_addr: IMG_AW must exceed 4");
      end
      if (FA_W < IMG_AW) begin : g_bad_fa
         $error("lpc_nor_addr: flash address narrower than image");
      end
   endgenerate

   // keep only the low image bits of the host address; older nibbles fall off the top
   logic [SH_W-1:0]   sh_q;
   logic [IMG_AW-1:0] img_cat;
   logic [FA_W-1:0]   mapped;

   assign img_cat = {sh_q, nib};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (nib_en) begin
         sh_q <= img_cat[SH_W-1:0];
      end
   end

   // bank placement: plain concatenation when it fits, otherwise a wrapping adder
   generate
      if (FA_W > SUM_W) begin : g_cat_pad
         assign mapped = {{(FA_W-SUM_W){1'b0}}, bank, img_cat};
      end else if (FA_W == SUM_W) begin : g_cat
         assign mapped = {bank, img_cat};
      end else begin : g_add
         logic [WIDE-1:0] wide;
         assign wide   = (WIDE'(bank) << IMG_AW) + WIDE'(img_cat);
         assign mapped = wide[FA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_addr <= '0;
      end else if (nib_last) begin
         fl_addr <= mapped;
      end
   end

   // R3: address only moves when a new last nibble arrives
   p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !nib_last |=> $stable(fl_addr));

endmodule

// File: rtl/lpc_nor_strobe.sv
module lpc_nor_strobe #(
   parameter int OE_WAIT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       clr,
   input  logic [7:0] fl_data,
   output logic       fl_oe_n,
   output logic       rdy,
   output logic [7:0] dat
);

   localparam int CW = (OE_WAIT > 1) ? $clog2(OE_WAIT) : 1;

   generate
      if (OE_WAIT < 3) begin : g_bad_wait
         $error("lpc_nor_strobe: OE_WAIT below 3 clocks");
      end
   endgenerate

   logic          active_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         rdy      <= 1'b0;
         dat      <= '0;
      end else if (clr) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         rdy      <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
         rdy      <= 1'b0;
      end else if (active_q) begin
         if (cnt_q == CW'(OE_WAIT - 1)) begin
            active_q <= 1'b0;
            rdy      <= 1'b1;
            dat      <= fl_data;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign fl_oe_n = !active_q;

   // R6: the byte is captured only after three clocks of enabled output
   p_oe_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> ($past(active_q, 1) && $past(active_q, 2) && $past(active_q, 3)));

endmodule

// File: rtl/lpc_nor_fsm.sv
module lpc_nor_fsm
   import lpc_nor_pkg::*;
#(
   parameter int ADDR_NIBS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       frame_n,
   input  logic [3:0] nib_i,
   input  logic       rdy,
   input  logic [7:0] dat,
   output logic       nib_en,
   output logic       nib_last,
   output logic       clr,
   output logic       in_sync_done,
   output logic [3:0] nib_o,
   output logic       nib_oe
);

   localparam int NCW = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;

   generate
      if (ADDR_NIBS < 2) begin : g_bad_nibs
         $error("lpc_nor_fsm: need at least two address nibbles");
      end
   endgenerate

   bus_st_e        st_q, st_d;
   logic [NCW-1:0] ncnt_q;

   always_comb begin
      st_d = st_q;
      if (!frame_n) begin
         st_d = (nib_i == NIB_START) ? ST_CTYP : ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:  st_d = ST_IDLE;
            ST_CTYP:  st_d = (nib_i == NIB_MEMRD) ? ST_ADDR : ST_IDLE;
            ST_ADDR:  st_d = (ncnt_q == NCW'(ADDR_NIBS - 1)) ? ST_HTAR0 : ST_ADDR;
            ST_HTAR0: st_d = ST_HTAR1;
            ST_HTAR1: st_d = ST_SWAIT;
            ST_SWAIT: st_d = rdy ? ST_SRDY : ST_SWAIT;
            ST_SRDY:  st_d = ST_DLO;
            ST_DLO:   st_d = ST_DHI;
            ST_DHI:   st_d = ST_TTAR0;
            ST_TTAR0: st_d = ST_TTAR1;
            ST_TTAR1: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ncnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_ADDR && frame_n) begin
            ncnt_q <= ncnt_q + 1'b1;
         end else begin
            ncnt_q <= '0;
         end
      end
   end

   assign nib_en       = (st_q == ST_ADDR) && frame_n;
   assign nib_last     = nib_en && (ncnt_q == NCW'(ADDR_NIBS - 1));
   assign clr          = !frame_n || (st_q == ST_SRDY);
   assign in_sync_done = (st_q == ST_SRDY);

   always_comb begin
      nib_oe = 1'b1;
      unique case (st_q)
         ST_SWAIT: nib_o = SYNC_LONG;
         ST_SRDY:  nib_o = SYNC_DONE;
         ST_DLO:   nib_o = dat[3:0];
         ST_DHI:   nib_o = dat[7:4];
         ST_TTAR0: nib_o = NIB_IDLE;
         default: begin
            nib_o  = NIB_IDLE;
            nib_oe = 1'b0;
         end
      endcase
   end

   // R2: a type nibble other than memory read sends the sequencer home
   p_type_filter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_CTYP && frame_n && nib_i != NIB_MEMRD) |=> (st_q == ST_IDLE));

   // R8: framing low with a nonzero nibble ends any cycle
   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n && nib_i != NIB_START) |=> (st_q == ST_IDLE));

   // R9: a start nibble is always taken, even mid-cycle
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n && nib_i == NIB_START) |=> (st_q == ST_CTYP));

endmodule

// File: rtl/lpc_nor_bridge.sv
module lpc_nor_bridge #(
   parameter int HOST_AW = 32,
   parameter int IMG_AW  = 18,
   parameter int BANK_W  = 2,
   parameter int FA_W    = 21,
   parameter int OE_WAIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        nib_i,
   output logic [3:0]        nib_o,
   output logic              nib_oe,
   input  logic [BANK_W-1:0] img_bank,
   output logic [FA_W-1:0]   nor_addr,
   input  logic [7:0]        nor_data,
   output logic              nor_oe_n,
   output logic              nor_we_n
);

   localparam int ADDR_NIBS = HOST_AW / 4;

   generate
      if (HOST_AW % 4 != 0) begin : g_bad_host
         $error("lpc_nor_bridge: host address must be whole nibbles");
      end
      if (IMG_AW > HOST_AW) begin : g_bad_img
         $error("lpc_nor_bridge: image larger than host window");
      end
   endgenerate

   logic       nib_en, nib_last, clr, rdy, in_sync_done;
   logic [7:0] dat;

   lpc_nor_fsm #(.ADDR_NIBS(ADDR_NIBS)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_n      (frame_n),
      .nib_i        (nib_i),
      .rdy          (rdy),
      .dat          (dat),
      .nib_en       (nib_en),
      .nib_last     (nib_last),
      .clr          (clr),
      .in_sync_done (in_sync_done),
      .nib_o        (nib_o),
      .nib_oe       (nib_oe)
   );

   lpc_nor_addr #(.IMG_AW(IMG_AW), .BANK_W(BANK_W), .FA_W(FA_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .nib_en   (nib_en),
      .nib_last (nib_last),
      .nib      (nib_i),
      .bank     (img_bank),
      .fl_addr  (nor_addr)
   );

   lpc_nor_strobe #(.OE_WAIT(OE_WAIT)) u_strobe (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (nib_last),
      .clr     (clr),
      .fl_data (nor_data),
      .fl_oe_n (nor_oe_n),
      .rdy     (rdy),
      .dat     (dat)
   );

   // reads only: the write strobe never moves
   assign nor_we_n = 1'b1;

   // R8: after an abort the bus and the flash are both released
   p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n && nib_i != 4'b0000) |=> (!nib_oe && nor_oe_n));

   // R3: the flash address holds while its output is enabled
   p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!nor_oe_n && $past(!nor_oe_n)) |-> $stable(nor_addr));

   // R7: the ready code is only sent once the flash is done
   p_ready_after_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_sync_done |-> (nor_oe_n && nib_oe && nib_o == 4'b0000));

   // R6: the flash is never enabled while the bridge is idle on the bus
   p_oe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!nor_oe_n) |-> (!nib_oe || nib_o == 4'b0101));

endmodule

// File: tb/sim_lpc_nor_bridge.sv
module sim_lpc_nor_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  nib_i = 4'hF;
   logic [3:0]  nib_o;
   logic        nib_oe;
   logic [1:0]  img_bank = 2'd0;
   logic [20:0] nor_addr;
   logic [7:0]  nor_data;
   logic        nor_oe_n;
   logic        nor_we_n;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   lpc_nor_bridge u0 (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .nib_i(nib_i),
      .nib_o(nib_o), .nib_oe(nib_oe), .img_bank(img_bank),
      .nor_addr(nor_addr), .nor_data(nor_data),
      .nor_oe_n(nor_oe_n), .nor_we_n(nor_we_n)
   );

   // flash model: data only valid once output enable has been low 3 clocks
   int oe_low = 0;
   function automatic logic [7:0] pat(logic [20:0] a);
      return a[7:0] ^ {a[20:16], a[13:11]} ^ 8'h3C;
   endfunction
   always @(negedge clk) oe_low <= nor_oe_n ? 0 : oe_low + 1;
   assign nor_data = (oe_low >= 3) ? pat(nor_addr) : 8'hEE;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard
   logic [7:0]  expq[$];
   logic [20:0] exp_faddr = '0;
   bit          we_low_seen = 0;

   initial begin : monitor
      int   ms = 0;
      bit   saw_wait = 0;
      logic [3:0] lo = 0;
      forever begin
         @(negedge clk);
         if (!rst_n) continue;
         if (!nor_we_n) we_low_seen = 1;
         if (!nor_oe_n)
            chk(nor_addr == exp_faddr, "R3/R4 flash address", 32'(nor_addr), 32'(exp_faddr));
         case (ms)
            0: if (nib_oe) begin
                  if (nib_o == 4'h5) saw_wait = 1;
                  else if (nib_o == 4'h0) begin
                     chk(saw_wait, "R7 wait before ready", 0, 1);
                     ms = 1;
                  end else chk(0, "R7 unexpected nibble", 32'(nib_o), 32'h5);
               end else saw_wait = 0;
            1: begin
                  chk(nib_oe, "R7 low data driven", 32'(nib_oe), 1);
                  lo = nib_o; ms = 2;
               end
            2: begin
                  if (expq.size() == 0)
                     chk(0, "R2 unexpected response", 32'({nib_o, lo}), 0);
                  else begin
                     logic [7:0] e;
                     e = expq.pop_front();
                     chk(nib_oe && {nib_o, lo} == e, "R6/R4 read data", 32'({nib_o, lo}), 32'(e));
                  end
                  ms = 3;
               end
            3: begin
                  chk(nib_oe && nib_o == 4'hF, "R7 trailing 1111", 32'({nib_oe, nib_o}), 32'h1F);
                  ms = 4;
               end
            default: begin
                  chk(!nib_oe, "R7 bus released", 32'(nib_oe), 0);
                  saw_wait = 0; ms = 0;
               end
         endcase
      end
   end

   task automatic header(input logic [3:0] typ, input logic [31:0] ha, input int nibs);
      @(negedge clk); frame_n = 1'b0; nib_i = 4'h0;
      @(negedge clk); frame_n = 1'b1; nib_i = typ;
      for (int i = 0; i < nibs; i++) begin
         @(negedge clk); nib_i = ha[31-4*i -: 4];
      end
   endtask

   task automatic do_read(input logic [31:0] ha, input logic [1:0] bk);
      img_bank = bk;
      exp_faddr = {1'b0, bk, ha[17:0]};
      expq.push_back(pat({1'b0, bk, ha[17:0]}));
      header(4'b0100, ha, 8);
      @(negedge clk); nib_i = 4'hF;
      chk(!nib_oe, "R7 turnaround 1 undriven", 32'(nib_oe), 0);
      @(negedge clk); nib_i = 4'hF;
      chk(!nib_oe, "R7 turnaround 2 undriven", 32'(nib_oe), 0);
      repeat (7) @(negedge clk);
   endtask

   task automatic do_other(input logic [3:0] typ);
      bit drove = 0, oe = 0;
      header(typ, 32'hFFFF_0000, 8);
      repeat (12) begin
         @(negedge clk);
         if (nib_oe) drove = 1;
         if (!nor_oe_n) oe = 1;
      end
      chk(!drove && !oe, "R2 non-read type ignored", 32'({drove, oe}), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      chk(!nib_oe && nor_oe_n && nor_we_n, "R1 reset state", 32'({nib_oe, nor_oe_n, nor_we_n}), 32'b011);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!nib_oe && nor_oe_n, "R1 idle after reset", 32'({nib_oe, nor_oe_n}), 32'b01);

      // R3/R4 address mapping across banks and mirrored host windows
      do_read(32'hFFF0_0000, 2'd0);
      do_read(32'h0000_0001, 2'd1);
      do_read(32'hFFFF_FFFF, 2'd3);
      do_read(32'h1234_5678, 2'd2);
      do_read(32'h0003_A5A5, 2'd0);
      do_read(32'hFF83_A5A5, 2'd0);   // R3 mirror of previous
      do_read(32'hABCD_EF01, 2'd1);

      // R2 other cycle types
      do_other(4'b0110);
      do_other(4'b0000);
      do_other(4'b1101);

      // R8 abort in the address phase
      header(4'b0100, 32'h0001_2345, 4);
      @(negedge clk); frame_n = 1'b0; nib_i = 4'hF;
      @(negedge clk); frame_n = 1'b1;
      chk(!nib_oe && nor_oe_n, "R8 abort in address", 32'({nib_oe, nor_oe_n}), 32'b01);
      repeat (10) @(negedge clk);
      chk(!nib_oe && nor_oe_n, "R8 stays idle after abort", 32'({nib_oe, nor_oe_n}), 32'b01);

      // R8 abort while waiting on the flash
      img_bank = 2'd2;
      exp_faddr = {1'b0, 2'd2, 18'h0BEEF};
      header(4'b0100, 32'h000B_EEEF & 32'hFFFF_FFFF, 8);
      exp_faddr = {1'b0, 2'd2, 18'h0EEEF ^ 18'h0EEEF ^ 18'h3EEEF & 18'h3EEEF};
      exp_faddr = {1'b0, 2'd2, 18'(32'h000B_EEEF)};
      @(negedge clk); nib_i = 4'hF;
      @(negedge clk);
      @(negedge clk);
      chk(nib_oe && nib_o == 4'h5, "R7 wait code driven", 32'({nib_oe, nib_o}), 32'h15);
      frame_n = 1'b0; nib_i = 4'hF;
      @(negedge clk); frame_n = 1'b1;
      chk(!nib_oe && nor_oe_n, "R8 abort in wait", 32'({nib_oe, nor_oe_n}), 32'b01);
      repeat (6) @(negedge clk);

      // R9 restart on top of an abort, then back-to-back reads
      header(4'b0100, 32'h0000_0000, 3);
      do_read(32'h0002_0F0F, 2'd3);
      do_read(32'h7777_1111, 2'd1);
      do_read(32'h0001_0000, 2'd2);
      repeat (4) @(negedge clk);

      chk(expq.size() == 0, "R9 all responses returned", 32'(expq.size()), 0);
      chk(!we_low_seen, "R5 write enable held high", 32'(we_low_seen), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule